// File: doc/BRIEF.md
# Descriptor Ring Pointer Walker

This block produces the memory address of the next DMA descriptor for one transmit ring and one receive ring. Each ring has a base address and a current pointer. Software sets a base address, and that write also moves the ring's pointer to the base. When the DMA engine finishes with a descriptor, it pulses the ring's advance strobe. With that strobe it also passes the descriptor's end-of-ring flag. The pointer then either returns to the ring base or steps forward by the descriptor stride that software configured for that ring.

The stride comes from a 32-bit DMA configuration word. Two 4-bit size fields in that word give the descriptor spacing in units of 8 bytes. The same word carries the burst sizes and the inter-frame-gap settings, which the block decodes and drives out for the DMA engine. A configuration write is refused if either descriptor size is smaller than the minimum descriptor size of 16 bytes. After a refused write the old configuration stays in place and a sticky error flag is set. Software clears that flag by writing a one to it.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset, both pointers are 0, both strides are 16 bytes, both burst fields and the gap count are 0, the gap-increment flag is 0 and `cfg_err` is 0.
- R2: A pulse on `rx_base_wr` or `tx_base_wr` stores `base_wdata` as that ring's base and current pointer. The new value is visible on the pointer output in the next cycle.
- R3: An advance strobe with the end-of-ring flag at 0 adds the ring's stride to its pointer in the next cycle. The receive stride is `cfg_wdata[15:12]`×8 bytes and the transmit stride is `cfg_wdata[19:16]`×8 bytes, both taken from the last accepted configuration.
- R4: An advance strobe with the end-of-ring flag at 1 loads the ring's base address into its pointer in the next cycle.
- R5: When a base write and an advance strobe hit the same ring in the same cycle, the base write wins, whatever the end-of-ring flag is.
- R6: A configuration write with both size fields at 2 or more is accepted. From the next cycle, the outputs show the receive burst from bits [9:8], the transmit burst from bits [11:10], the gap count from bits [22:20], the gap-increment flag from bit 23, and the new strides.
- R7: A configuration write with either size field below 2 changes none of the decoded outputs. It sets `cfg_err` in the next cycle.
- R8: `cfg_err` stays set until `sts_wr` is pulsed with `sts_wdata`=1. A pulse with `sts_wdata`=0 has no effect. If a refused configuration write and a clear happen in the same cycle, the flag stays set.
- R9: Pointer arithmetic wraps modulo 2^AW.
- R10: A ring that gets neither a base write nor an advance keeps its pointer, whatever the other ring does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | A value of 1 clears the error flag |
| rx_base_wr | input | 1 | Load receive base and pointer |
| tx_base_wr | input | 1 | Load transmit base and pointer |
| base_wdata | input | AW | Base address to load |
| rx_adv | input | 1 | Receive descriptor consumed |
| rx_eor | input | 1 | End-of-ring flag of the consumed receive descriptor |
| tx_adv | input | 1 | Transmit descriptor consumed |
| tx_eor | input | 1 | End-of-ring flag of the consumed transmit descriptor |
| rx_ptr | output | AW | Current receive descriptor address |
| tx_ptr | output | AW | Current transmit descriptor address |
| rx_stride | output | SW | Receive stride in bytes |
| tx_stride | output | SW | Transmit stride in bytes |
| rx_burst | output | 2 | Receive burst code |
| tx_burst | output | 2 | Transmit burst code |
| ifg_cnt | output | 3 | Inter-frame-gap count |
| ifg_inc | output | 1 | Inter-frame-gap increment flag |
| cfg_err | output | 1 | Sticky flag for a refused configuration |

## Verification
The walker is exercised with four kinds of sequence:
- Plain advances at the reset stride and at two different per-ring strides (32 and 24 bytes). These show that each ring uses its own size field and not the other ring's.
- End-of-ring advances on both rings at once. These separate a wrap back to the base from a plain step.
- Refused configurations, one with a too-small transmit size and one with a too-small receive size. These show that either field alone triggers refusal. A write at exactly the minimum is accepted, which marks the boundary.
- Collisions: a base write at the same time as an advance, a wrap at the top of the address space, and a clear at the same time as a refusal. These fix the priority order.

// File: rtl/drw_pkg.sv
package drw_pkg;

    // Bit positions of the configuration word; the DMA engine decodes these.
    localparam int RXB_LSB  = 8;
    localparam int TXB_LSB  = 10;
    localparam int RXS_LSB  = 12;
    localparam int TXS_LSB  = 16;
    localparam int GAP_LSB  = 20;
    localparam int GINC_BIT = 23;
    localparam int SIZE_W   = 4;

    typedef struct packed {
        logic              gap_inc;
        logic [2:0]        gap_cnt;
        logic [SIZE_W-1:0] tx_size;
        logic [SIZE_W-1:0] rx_size;
        logic [1:0]        tx_burst;
        logic [1:0]        rx_burst;
    } dma_cfg_t;

    function automatic dma_cfg_t decode_cfg(input logic [31:0] w);
        dma_cfg_t c;
        c.rx_burst = w[RXB_LSB +: 2];
        c.tx_burst = w[TXB_LSB +: 2];
        c.rx_size  = w[RXS_LSB +: SIZE_W];
        c.tx_size  = w[TXS_LSB +: SIZE_W];
        c.gap_cnt  = w[GAP_LSB +: 3];
        c.gap_inc  = w[GINC_BIT];
        return c;
    endfunction

endpackage

// File: rtl/drw_cfg.sv
module drw_cfg
    import drw_pkg::*;
#(
    parameter int MIN_FIELD = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic     sts_wr,
    input  logic     sts_wdata,
    output dma_cfg_t cfg,
    output logic     err
);

    typedef struct packed {
        dma_cfg_t cfg;
        logic     err;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    dma_cfg_t   cand;
    logic       too_small;

    always_comb begin
        st_d      = st_q;
        cand      = decode_cfg(cfg_wdata);
        too_small = (cand.rx_size < SIZE_W'(MIN_FIELD)) ||
                    (cand.tx_size < SIZE_W'(MIN_FIELD));
        if (sts_wr && sts_wdata) begin
            st_d.err = 1'b0;
        end
        if (cfg_wr) begin
            if (too_small) begin
                st_d.err = 1'b1;
            end else begin
                st_d.cfg = cand;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q             <= '0;
            st_q.cfg.rx_size <= SIZE_W'(MIN_FIELD);
            st_q.cfg.tx_size <= SIZE_W'(MIN_FIELD);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;
    assign err = st_q.err;

endmodule

// File: rtl/drw_ring_ptr.sv
module drw_ring_ptr #(
    parameter int AW = 32,
    parameter int SW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          adv,
    input  logic          eor,
    input  logic [SW-1:0] stride,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] base
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] ptr;
    } ring_state_t;

    ring_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (base_wr) begin
            st_d.base = base_wdata;
            st_d.ptr  = base_wdata;
        end else if (adv) begin
            st_d.ptr = eor ? st_q.base : st_q.ptr + AW'(stride);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr  = st_q.ptr;
    assign base = st_q.base;

endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
    import drw_pkg::*;
#(
    parameter int AW             = 32,
    parameter int UNIT_BYTES     = 8,
    parameter int MIN_DESC_BYTES = 16,
    localparam int SW            = $clog2(((1 << SIZE_W) - 1) * UNIT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [31:0]   cfg_wdata,
    input  logic          sts_wr,
    input  logic          sts_wdata,
    input  logic          rx_base_wr,
    input  logic          tx_base_wr,
    input  logic [AW-1:0] base_wdata,
    input  logic          rx_adv,
    input  logic          rx_eor,
    input  logic          tx_adv,
    input  logic          tx_eor,
    output logic [AW-1:0] rx_ptr,
    output logic [AW-1:0] tx_ptr,
    output logic [SW-1:0] rx_stride,
    output logic [SW-1:0] tx_stride,
    output logic [1:0]    rx_burst,
    output logic [1:0]    tx_burst,
    output logic [2:0]    ifg_cnt,
    output logic          ifg_inc,
    output logic          cfg_err
);

    localparam int MIN_FIELD = (MIN_DESC_BYTES + UNIT_BYTES - 1) / UNIT_BYTES;
    localparam int NRING     = 2;  // index 0 receive, 1 transmit

    dma_cfg_t      cfg;
    logic          base_wr_v [NRING];
    logic          adv_v     [NRING];
    logic          eor_v     [NRING];
    logic [SW-1:0] stride_v  [NRING];
    logic [AW-1:0] ptr_v     [NRING];
    logic [AW-1:0] base_v    [NRING];

    drw_cfg #(.MIN_FIELD(MIN_FIELD)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .sts_wr    (sts_wr),
        .sts_wdata (sts_wdata),
        .cfg       (cfg),
        .err       (cfg_err)
    );

    assign stride_v[0]  = SW'(cfg.rx_size) * SW'(UNIT_BYTES);
    assign stride_v[1]  = SW'(cfg.tx_size) * SW'(UNIT_BYTES);
    assign base_wr_v[0] = rx_base_wr;
    assign base_wr_v[1] = tx_base_wr;
    assign adv_v[0]     = rx_adv;
    assign adv_v[1]     = tx_adv;
    assign eor_v[0]     = rx_eor;
    assign eor_v[1]     = tx_eor;

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        drw_ring_ptr #(.AW(AW), .SW(SW)) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .base_wr    (base_wr_v[g]),
            .base_wdata (base_wdata),
            .adv        (adv_v[g]),
            .eor        (eor_v[g]),
            .stride     (stride_v[g]),
            .ptr        (ptr_v[g]),
            .base       (base_v[g])
        );
    end

    assign rx_ptr    = ptr_v[0];
    assign tx_ptr    = ptr_v[1];
    assign rx_stride = stride_v[0];
    assign tx_stride = stride_v[1];
    assign rx_burst  = cfg.rx_burst;
    assign tx_burst  = cfg.tx_burst;
    assign ifg_cnt   = cfg.gap_cnt;
    assign ifg_inc   = cfg.gap_inc;

endmodule

// File: rtl/drw_checker.sv
module drw_checker #(
    parameter int AW        = 32,
    parameter int SW        = 7,
    parameter int MIN_FIELD = 2,
    parameter int MIN_BYTES = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [31:0]   cfg_wdata,
    input logic          sts_wr,
    input logic          sts_wdata,
    input logic          rx_base_wr,
    input logic          tx_base_wr,
    input logic [AW-1:0] base_wdata,
    input logic          rx_adv,
    input logic          rx_eor,
    input logic          tx_adv,
    input logic          tx_eor,
    input logic [AW-1:0] rx_ptr,
    input logic [AW-1:0] tx_ptr,
    input logic [AW-1:0] rx_base,
    input logic [AW-1:0] tx_base,
    input logic [SW-1:0] rx_stride,
    input logic [SW-1:0] tx_stride,
    input logic          cfg_err
);

    logic bad_cfg;
    assign bad_cfg = (cfg_wdata[15:12] < 4'(MIN_FIELD)) ||
                     (cfg_wdata[19:16] < 4'(MIN_FIELD));

    p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_base_wr |=> rx_ptr == $past(base_wdata));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_adv && !tx_eor && !tx_base_wr) |=>
            tx_ptr == $past(tx_ptr) + AW'($past(tx_stride)));

    p_wrap_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_adv && rx_eor && !rx_base_wr) |=> rx_ptr == $past(rx_base));

    p_base_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_base_wr && tx_adv) |=> tx_ptr == $past(base_wdata));

    p_stride_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_stride) >= MIN_BYTES) && (32'(tx_stride) >= MIN_BYTES));

    p_reject_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && bad_cfg) |=> cfg_err && $stable(rx_stride) && $stable(tx_stride));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !(sts_wr && sts_wdata)) |=> cfg_err);

    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && sts_wdata && !(cfg_wr && bad_cfg)) |=> !cfg_err);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_adv && !rx_base_wr) |=> $stable(rx_ptr));

    p_idle_hold_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_adv && !tx_base_wr) |=> $stable(tx_ptr) && $stable(tx_base));

endmodule

bind desc_ring_walker drw_checker #(
    .AW        (AW),
    .SW        (SW),
    .MIN_FIELD (MIN_FIELD),
    .MIN_BYTES (MIN_DESC_BYTES)
) u_drw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .sts_wr     (sts_wr),
    .sts_wdata  (sts_wdata),
    .rx_base_wr (rx_base_wr),
    .tx_base_wr (tx_base_wr),
    .base_wdata (base_wdata),
    .rx_adv     (rx_adv),
    .rx_eor     (rx_eor),
    .tx_adv     (tx_adv),
    .tx_eor     (tx_eor),
    .rx_ptr     (rx_ptr),
    .tx_ptr     (tx_ptr),
    .rx_base    (base_v[0]),
    .tx_base    (base_v[1]),
    .rx_stride  (rx_stride),
    .tx_stride  (tx_stride),
    .cfg_err    (cfg_err)
);

// File: tb/desc_ring_walker_test.sv
module desc_ring_walker_test;

    localparam int AW = 32;
    localparam int SW = 7;

    localparam logic [2:0] OP_NOP = 3'd0, OP_RXB = 3'd1, OP_TXB = 3'd2, OP_RXA = 3'd3,
                           OP_TXA = 3'd4, OP_CFG = 3'd5, OP_CLR = 3'd6, OP_BOTH = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] data;
        logic        eor;
        logic [31:0] exp_rx;
        logic [31:0] exp_tx;
        logic [7:0]  exp_rs;
        logic [7:0]  exp_ts;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{OP_RXB,  32'h1000,     1'b0, 32'h1000, 32'h0000, 8'd16, 8'd16, 1'b0, 4'd2},  // R2
        '{OP_TXB,  32'h2000,     1'b0, 32'h1000, 32'h2000, 8'd16, 8'd16, 1'b0, 4'd2},  // R2
        '{OP_RXA,  32'h0,        1'b0, 32'h1010, 32'h2000, 8'd16, 8'd16, 1'b0, 4'd3},  // R3
        '{OP_RXA,  32'h0,        1'b0, 32'h1020, 32'h2000, 8'd16, 8'd16, 1'b0, 4'd10}, // R10
        '{OP_TXA,  32'h0,        1'b0, 32'h1020, 32'h2010, 8'd16, 8'd16, 1'b0, 4'd3},  // R3
        '{OP_CFG,  32'h00D34900, 1'b0, 32'h1020, 32'h2010, 8'd32, 8'd24, 1'b0, 4'd6},  // R6
        '{OP_RXA,  32'h0,        1'b0, 32'h1040, 32'h2010, 8'd32, 8'd24, 1'b0, 4'd3},  // R3
        '{OP_TXA,  32'h0,        1'b0, 32'h1040, 32'h2028, 8'd32, 8'd24, 1'b0, 4'd3},  // R3
        '{OP_BOTH, 32'h0,        1'b1, 32'h1000, 32'h2000, 8'd32, 8'd24, 1'b0, 4'd4},  // R4
        '{OP_CFG,  32'h00014000, 1'b0, 32'h1000, 32'h2000, 8'd32, 8'd24, 1'b1, 4'd7},  // R7
        '{OP_CFG,  32'h000F0000, 1'b0, 32'h1000, 32'h2000, 8'd32, 8'd24, 1'b1, 4'd7},  // R7
        '{OP_CLR,  32'h0,        1'b0, 32'h1000, 32'h2000, 8'd32, 8'd24, 1'b1, 4'd8},  // R8
        '{OP_CLR,  32'h1,        1'b0, 32'h1000, 32'h2000, 8'd32, 8'd24, 1'b0, 4'd8},  // R8
        '{OP_CFG,  32'h00022000, 1'b0, 32'h1000, 32'h2000, 8'd16, 8'd16, 1'b0, 4'd6},  // R6
        '{OP_RXA,  32'h0,        1'b0, 32'h1010, 32'h2000, 8'd16, 8'd16, 1'b0, 4'd3}   // R3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0, sts_wr = 1'b0, sts_wdata = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          rx_base_wr = 1'b0, tx_base_wr = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic          rx_adv = 1'b0, rx_eor = 1'b0, tx_adv = 1'b0, tx_eor = 1'b0;
    logic [AW-1:0] rx_ptr, tx_ptr;
    logic [SW-1:0] rx_stride, tx_stride;
    logic [1:0]    rx_burst, tx_burst;
    logic [2:0]    ifg_cnt;
    logic          ifg_inc, cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    desc_ring_walker uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .rx_base_wr(rx_base_wr),
        .tx_base_wr(tx_base_wr), .base_wdata(base_wdata), .rx_adv(rx_adv),
        .rx_eor(rx_eor), .tx_adv(tx_adv), .tx_eor(tx_eor), .rx_ptr(rx_ptr),
        .tx_ptr(tx_ptr), .rx_stride(rx_stride), .tx_stride(tx_stride),
        .rx_burst(rx_burst), .tx_burst(tx_burst), .ifg_cnt(ifg_cnt),
        .ifg_inc(ifg_inc), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Inputs are applied at a falling edge; one rising edge later they are
    // removed and the registered outputs are sampled.
    task automatic step();
        @(negedge clk);
        cfg_wr = 1'b0; sts_wr = 1'b0; sts_wdata = 1'b0;
        rx_base_wr = 1'b0; tx_base_wr = 1'b0;
        rx_adv = 1'b0; rx_eor = 1'b0; tx_adv = 1'b0; tx_eor = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        case (v.op)
            OP_RXB:  begin rx_base_wr = 1'b1; base_wdata = v.data; end
            OP_TXB:  begin tx_base_wr = 1'b1; base_wdata = v.data; end
            OP_RXA:  begin rx_adv = 1'b1; rx_eor = v.eor; end
            OP_TXA:  begin tx_adv = 1'b1; tx_eor = v.eor; end
            OP_CFG:  begin cfg_wr = 1'b1; cfg_wdata = v.data; end
            OP_CLR:  begin sts_wr = 1'b1; sts_wdata = v.data[0]; end
            OP_BOTH: begin rx_adv = 1'b1; tx_adv = 1'b1; rx_eor = v.eor; tx_eor = v.eor; end
            default: ;
        endcase
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rx_ptr", rx_ptr, 0);
        chk("R1 tx_ptr", tx_ptr, 0);
        chk("R1 rx_stride", 32'(rx_stride), 16);
        chk("R1 tx_stride", 32'(tx_stride), 16);
        chk("R1 fields", {26'd0, rx_burst, tx_burst, ifg_cnt, ifg_inc} >> 0, 0);
        chk("R1 cfg_err", 32'(cfg_err), 0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            step();
            chk($sformatf("R%0d vec%0d rx_ptr", VECS[i].req, i), rx_ptr, VECS[i].exp_rx);
            chk($sformatf("R%0d vec%0d tx_ptr", VECS[i].req, i), tx_ptr, VECS[i].exp_tx);
            chk($sformatf("R%0d vec%0d rx_stride", VECS[i].req, i), 32'(rx_stride), 32'(VECS[i].exp_rs));
            chk($sformatf("R%0d vec%0d tx_stride", VECS[i].req, i), 32'(tx_stride), 32'(VECS[i].exp_ts));
            chk($sformatf("R%0d vec%0d cfg_err", VECS[i].req, i), 32'(cfg_err), 32'(VECS[i].exp_err));
        end

        // R9 wrap at the top of the address space (stride 16)
        rx_base_wr = 1'b1; base_wdata = 32'hFFFF_FFF0;
        step();
        rx_adv = 1'b1;
        step();
        chk("R9 rx_ptr wrap", rx_ptr, 32'h0);

        // R5 base write beats advance, with and without end-of-ring
        tx_base_wr = 1'b1; base_wdata = 32'h3000; tx_adv = 1'b1; tx_eor = 1'b0;
        step();
        chk("R5 tx_ptr base wins", tx_ptr, 32'h3000);
        rx_base_wr = 1'b1; base_wdata = 32'h4400; rx_adv = 1'b1; rx_eor = 1'b1;
        step();
        chk("R5 rx_ptr base wins eor", rx_ptr, 32'h4400);
        chk("R10 tx_ptr untouched", tx_ptr, 32'h3000);

        // R6 decoded fields: rx burst 1, tx burst 2, gap 5, increment 1
        cfg_wr = 1'b1; cfg_wdata = 32'h00D34900;
        step();
        chk("R6 rx_burst", 32'(rx_burst), 1);
        chk("R6 tx_burst", 32'(tx_burst), 2);
        chk("R6 ifg_cnt", 32'(ifg_cnt), 5);
        chk("R6 ifg_inc", 32'(ifg_inc), 1);

        // R7 refused word leaves every field alone
        cfg_wr = 1'b1; cfg_wdata = 32'h0000_0000;
        step();
        chk("R7 rx_burst kept", 32'(rx_burst), 1);
        chk("R7 tx_burst kept", 32'(tx_burst), 2);
        chk("R7 ifg kept", {28'd0, ifg_cnt, ifg_inc}, 32'hB);
        chk("R7 err set", 32'(cfg_err), 1);

        // R8 refusal and clear in one cycle: set wins
        cfg_wr = 1'b1; cfg_wdata = 32'h0001_1000; sts_wr = 1'b1; sts_wdata = 1'b1;
        step();
        chk("R8 set wins", 32'(cfg_err), 1);
        sts_wr = 1'b1; sts_wdata = 1'b1;
        step();
        chk("R8 cleared", 32'(cfg_err), 0);

        finish_run();
    end

endmodule